// File: doc/BRIEF.md
# Accumulator ALU with Carry and Zero Flags

This block is the arithmetic heart of a small 8-bit accumulator machine. It holds the accumulator and the carry flag in registers. Each enabled cycle it applies one operation from a 4-bit select to them, using an operand word that the surrounding machine has already read from memory. The operations are:

- one's complement;
- rotate by one place in either direction;
- clear accumulator;
- clear carry;
- increment and decrement;
- AND with the operand;
- add the operand plus the carry;
- load the operand.

The zero flag is decoded combinationally from the registered accumulator, so that a jump-if-not-zero test can read it in the cycle after the update.

Fetch, decode, addressing and the program counter lie outside the block. The sequencer drives `step_en` high for exactly the cycles in which an instruction should touch the accumulator or carry. It holds `step_en` low otherwise. No data stream passes through the block, so all pins are plain control and data levels with no handshake. Back-pressure does not arise: an enabled cycle always completes in one clock.

Top module: `acc_alu_unit`

## Requirements
- R1: When `rst` is high at a rising edge, the accumulator and carry both become 0 at that edge, whatever `step_en` and `op_sel` are.
- R2: When `step_en` is low at a rising edge, the accumulator and carry keep their values for every `op_sel`.
- R3: Code 1 (complement) sets the accumulator to its bitwise inverse and leaves the carry unchanged.
- R4: Code 2 (rotate toward LSB) moves each bit i to position i-1 and moves bit 0 into bit 7. The carry is unchanged.
- R5: Code 3 (rotate toward MSB) moves each bit i to position i+1 and moves bit 7 into bit 0. The carry is unchanged.
- R6: Code 4 clears the accumulator and leaves the carry unchanged. Code 5 clears the carry and leaves the accumulator unchanged.
- R7: Code 6 adds one to the accumulator and code 7 subtracts one, both modulo 256 (FF+1 gives 00, 00-1 gives FF). Neither changes the carry.
- R8: Code 8 sets the accumulator to the accumulator ANDed with `mem_data`. The carry is unchanged.
- R9: Code 9 computes accumulator + `mem_data` + carry. The low 8 bits go to the accumulator and bit 8 goes to the carry.
- R10: Code 10 copies `mem_data` into the accumulator. The carry is unchanged.
- R11: `zero_flag` is high exactly when the registered accumulator is 0, with no added register delay.
- R12: Code 0 and codes 11 to 15 leave the accumulator and carry unchanged even when `step_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Apply `op_sel` at this edge |
| op_sel | input | 4 | Operation select code |
| mem_data | input | 8 | Operand word from memory |
| acc_q | output | 8 | Registered accumulator |
| carry_q | output | 1 | Registered carry flag |
| zero_flag | output | 1 | High when `acc_q` is zero |

## Verification
Each accumulator and carry result is due on the first rising edge at which `step_en` and the operands are sampled. `zero_flag` follows in the same cycle, because it is decoded directly from the register. The bench changes inputs one time unit after a rising edge, waits for the next edge, and reads all three outputs one time unit after it. Every check therefore looks at the value produced by exactly one step. Chains of steps run from a known state, so that carry-in, wrap-around and flag effects of earlier steps are expected explicitly.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_HOLD   = 4'd0,
    OP_CPL    = 4'd1,
    OP_ROT_DN = 4'd2,
    OP_ROT_UP = 4'd3,
    OP_CLR_A  = 4'd4,
    OP_CLR_C  = 4'd5,
    OP_INC    = 4'd6,
    OP_DEC    = 4'd7,
    OP_AND    = 4'd8,
    OP_ADC    = 4'd9,
    OP_LOAD   = 4'd10
  } op_e;
endpackage

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    acc,
  input  logic [W-1:0]    opnd,
  output logic [W-1:0]    res,
  output logic            hit
);
  logic [W-1:0] rot_dn;
  logic [W-1:0] rot_up;

  // Rotates built bit by bit; the wrap bits close the ring.
  for (genvar i = 0; i < W; i++) begin : g_rot
    assign rot_dn[i] = acc[(i + 1) % W];
    assign rot_up[i] = acc[(i + W - 1) % W];
  end

  always_comb begin
    res = acc;
    hit = 1'b1;
    case (op)
      OP_CPL:    res = ~acc;
      OP_ROT_DN: res = rot_dn;
      OP_ROT_UP: res = rot_up;
      OP_CLR_A:  res = '0;
      OP_AND:    res = acc & opnd;
      OP_LOAD:   res = opnd;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    acc,
  input  logic [W-1:0]    opnd,
  input  logic            cin,
  output logic [W-1:0]    sum,
  output logic            cout,
  output logic            hit
);
  localparam int SW = W + 1;

  logic [W-1:0]  addend;
  logic          carry_in;
  logic [SW-1:0] total;

  // One shared adder: increment adds 1, decrement adds all-ones.
  always_comb begin
    addend   = '0;
    carry_in = 1'b0;
    hit      = 1'b1;
    case (op)
      OP_INC: addend = {{(W-1){1'b0}}, 1'b1};
      OP_DEC: addend = '1;
      OP_ADC: begin
        addend   = opnd;
        carry_in = cin;
      end
      default: hit = 1'b0;
    endcase
  end

  assign total = {1'b0, acc} + {1'b0, addend} + SW'(carry_in);
  assign sum   = total[W-1:0];
  assign cout  = total[W];
endmodule

// File: rtl/acc_alu_next.sv
module acc_alu_next
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    acc,
  input  logic            carry,
  input  logic [W-1:0]    logic_res,
  input  logic            logic_hit,
  input  logic [W-1:0]    arith_sum,
  input  logic            arith_cout,
  input  logic            arith_hit,
  output logic [W-1:0]    acc_nx,
  output logic            carry_nx
);
  always_comb begin
    acc_nx   = acc;
    carry_nx = carry;
    if (logic_hit) begin
      acc_nx = logic_res;
    end else if (arith_hit) begin
      acc_nx = arith_sum;
      if (op == OP_ADC) carry_nx = arith_cout;
    end else if (op == OP_CLR_C) begin
      carry_nx = 1'b0;
    end
  end
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_en,
  input  logic [OP_W-1:0] op_sel,
  input  logic [W-1:0]    mem_data,
  output logic [W-1:0]    acc_q,
  output logic            carry_q,
  output logic            zero_flag
);
  logic [W-1:0] logic_res;
  logic         logic_hit;
  logic [W-1:0] arith_sum;
  logic         arith_cout;
  logic         arith_hit;
  logic [W-1:0] acc_nx;
  logic         carry_nx;

  acc_alu_logic #(.W(W)) u_logic (
    .op(op_sel), .acc(acc_q), .opnd(mem_data), .res(logic_res), .hit(logic_hit)
  );

  acc_alu_arith #(.W(W)) u_arith (
    .op(op_sel), .acc(acc_q), .opnd(mem_data), .cin(carry_q),
    .sum(arith_sum), .cout(arith_cout), .hit(arith_hit)
  );

  acc_alu_next #(.W(W)) u_next (
    .op(op_sel), .acc(acc_q), .carry(carry_q),
    .logic_res(logic_res), .logic_hit(logic_hit),
    .arith_sum(arith_sum), .arith_cout(arith_cout), .arith_hit(arith_hit),
    .acc_nx(acc_nx), .carry_nx(carry_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (step_en) begin
      acc_q   <= acc_nx;
      carry_q <= carry_nx;
    end
  end

  assign zero_flag = (acc_q == '0);
endmodule

// File: rtl/acc_alu_checks.sv
module acc_alu_checks
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            step_en,
  input logic [OP_W-1:0] op_sel,
  input logic [W-1:0]    mem_data,
  input logic [W-1:0]    acc_q,
  input logic            carry_q,
  input logic            zero_flag
);
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (acc_q == '0 && !carry_q));

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(acc_q) && $stable(carry_q)));

  a_r3_complement: assert property (@(posedge clk) disable iff (rst)
    (step_en && op_sel == OP_CPL) |=> (acc_q == ~$past(acc_q) && $stable(carry_q)));

  a_r7_inc_keeps_carry: assert property (@(posedge clk) disable iff (rst)
    (step_en && (op_sel == OP_INC || op_sel == OP_DEC)) |=> $stable(carry_q));

  a_r9_add_with_carry: assert property (@(posedge clk) disable iff (rst)
    (step_en && op_sel == OP_ADC) |=>
      ({carry_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(mem_data)} + (W+1)'($past(carry_q)))));

  a_r10_load: assert property (@(posedge clk) disable iff (rst)
    (step_en && op_sel == OP_LOAD) |=> (acc_q == $past(mem_data)));

  a_r11_zero_after_clear: assert property (@(posedge clk) disable iff (rst)
    (step_en && op_sel == OP_CLR_A) |=> zero_flag);

  a_r12_unused_hold: assert property (@(posedge clk) disable iff (rst)
    (step_en && (op_sel == OP_HOLD || op_sel > OP_LOAD)) |=> ($stable(acc_q) && $stable(carry_q)));
endmodule

bind acc_alu_unit acc_alu_checks #(.W(W)) u_checks (
  .clk(clk), .rst(rst), .step_en(step_en), .op_sel(op_sel), .mem_data(mem_data),
  .acc_q(acc_q), .carry_q(carry_q), .zero_flag(zero_flag)
);

// File: tb/acc_alu_unit_test.sv
module acc_alu_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_en = 1'b0;
  logic [3:0] op_sel = 4'd0;
  logic [7:0] mem_data = 8'h00;
  logic [7:0] acc_q;
  logic       carry_q;
  logic       zero_flag;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  acc_alu_unit uut (
    .clk(clk), .rst(rst), .step_en(step_en), .op_sel(op_sel), .mem_data(mem_data),
    .acc_q(acc_q), .carry_q(carry_q), .zero_flag(zero_flag)
  );

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Check {zero, carry, acc} in one go.
  task automatic expect_state(input string req, input logic [7:0] a, input logic c);
    check(req, {zero_flag, carry_q, acc_q}, {(a == 8'h00), c, a});
  endtask

  task automatic step(input logic en, input logic [3:0] op, input logic [7:0] m);
    step_en  = en;
    op_sel   = op;
    mem_data = m;
    @(posedge clk);
    #1;
    step_en = 1'b0;
  endtask

  // Bring A and C to a known state through the normal interface.
  task automatic set_state(input logic [7:0] a, input logic c);
    step(1'b1, 4'd4, 8'h00);
    step(1'b1, 4'd5, 8'h00);
    if (c) begin
      step(1'b1, 4'd10, 8'hFF);
      step(1'b1, 4'd9, 8'h01);
    end
    step(1'b1, 4'd10, a);
  endtask

  task automatic t_reset;
    set_state(8'h5A, 1'b1);
    rst = 1'b1;
    step(1'b1, 4'd10, 8'h77);
    rst = 1'b0;
    expect_state("R1 reset clears", 8'h00, 1'b0);
  endtask

  task automatic t_idle;
    set_state(8'h3C, 1'b1);
    for (int k = 0; k < 16; k++) begin
      step(1'b0, 4'(k), 8'hA5);
    end
    expect_state("R2 hold when step_en low", 8'h3C, 1'b1);
  endtask

  task automatic t_complement;
    set_state(8'hC3, 1'b1);
    step(1'b1, 4'd1, 8'h00);
    expect_state("R3 complement", 8'h3C, 1'b1);
    set_state(8'hFF, 1'b0);
    step(1'b1, 4'd1, 8'h00);
    expect_state("R3 complement to zero", 8'h00, 1'b0);
  endtask

  task automatic t_rotates;
    set_state(8'h96, 1'b0);
    step(1'b1, 4'd2, 8'h00);
    expect_state("R4 rotate toward LSB", 8'h4B, 1'b0);
    step(1'b1, 4'd2, 8'h00);
    expect_state("R4 rotate wraps bit 0", 8'hA5, 1'b0);
    set_state(8'h96, 1'b1);
    step(1'b1, 4'd3, 8'h00);
    expect_state("R5 rotate toward MSB wraps bit 7", 8'h2D, 1'b1);
  endtask

  task automatic t_clears;
    set_state(8'h81, 1'b1);
    step(1'b1, 4'd4, 8'hFF);
    expect_state("R6 clear accumulator", 8'h00, 1'b1);
    set_state(8'h81, 1'b1);
    step(1'b1, 4'd5, 8'hFF);
    expect_state("R6 clear carry", 8'h81, 1'b0);
  endtask

  task automatic t_incdec;
    set_state(8'hFF, 1'b0);
    step(1'b1, 4'd6, 8'h00);
    expect_state("R7 increment wraps, carry kept", 8'h00, 1'b0);
    set_state(8'h00, 1'b1);
    step(1'b1, 4'd7, 8'h00);
    expect_state("R7 decrement wraps, carry kept", 8'hFF, 1'b1);
    set_state(8'h40, 1'b1);
    step(1'b1, 4'd6, 8'h00);
    expect_state("R7 increment no carry-in", 8'h41, 1'b1);
  endtask

  task automatic t_and;
    set_state(8'hF0, 1'b1);
    step(1'b1, 4'd8, 8'h3C);
    expect_state("R8 and with operand", 8'h30, 1'b1);
  endtask

  task automatic t_adc;
    logic [8:0] s;
    set_state(8'hF0, 1'b0);
    step(1'b1, 4'd9, 8'h10);
    expect_state("R9 add sets carry", 8'h00, 1'b1);
    step(1'b1, 4'd9, 8'h01);
    expect_state("R9 add uses carry-in", 8'h02, 1'b0);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] a = 8'(8'h37 * (k + 1));
      logic [7:0] m = 8'(8'hB5 + 8'(k * 29));
      logic       c = k[0];
      set_state(a, c);
      s = {1'b0, a} + {1'b0, m} + 9'(c);
      step(1'b1, 4'd9, m);
      expect_state("R9 add pattern", s[7:0], s[8]);
    end
  endtask

  task automatic t_load;
    set_state(8'h11, 1'b1);
    step(1'b1, 4'd10, 8'hE7);
    expect_state("R10 load operand", 8'hE7, 1'b1);
  endtask

  task automatic t_zero;
    set_state(8'h01, 1'b0);
    check("R11 zero low for nonzero", {9'd0, zero_flag}, 10'd0);
    step(1'b1, 4'd7, 8'h00);
    check("R11 zero high same cycle", {9'd0, zero_flag}, 10'd1);
  endtask

  task automatic t_unused;
    set_state(8'h6D, 1'b1);
    step(1'b1, 4'd0, 8'h00);
    expect_state("R12 code 0 holds", 8'h6D, 1'b1);
    for (int k = 11; k < 16; k++) begin
      step(1'b1, 4'(k), 8'h00);
      expect_state("R12 unused code holds", 8'h6D, 1'b1);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(posedge clk);
    @(posedge clk);
    #1;
    rst = 1'b0;
    expect_state("R1 state after reset", 8'h00, 1'b0);
    t_reset();
    t_idle();
    t_complement();
    t_rotates();
    t_clears();
    t_incdec();
    t_and();
    t_adc();
    t_load();
    t_zero();
    t_unused();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule